// File: doc/BRIEF.md
# Flash Read-Protection Lock Controller

This block sits between the access ports of an on-chip flash array and the array itself. It decides, for every access, whether the access goes through. Accesses come from the on-chip side in user boot mode or from the serial-programming port, and some are flagged as coming from the debug port. The block holds a model of the non-volatile security word and of its companion trim word. Programming a protection code into the security word arms a lock. The lock does not take effect when the code is written. It takes effect when the next reset samples the stored word.

While the lock is active, the debug port cannot touch the flash at all. User boot mode keeps full access. Every other boot mode may read, but reads come back as all ones with no valid flag. In those modes only a chip erase is accepted. A chip erase blanks both protected words, and the next reset releases the lock. A sector erase aimed at either protected word blanks both words together.

Each request is one cycle wide. The response comes on the following cycle as registered outputs: a grant, a read-valid flag, read data, and a one-cycle denial pulse. `por_ni` models a power cycle on a blank part. It returns the stored words to the erased value. `rst_ni` is the ordinary reset that samples the lock.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The security word lives at address 0x0010_0000 and the trim word at 0x0010_0004. Programming (kind 01) either word can only clear bits: the new value is the old value ANDed with the write data. A granted read (kind 00) of either address returns the stored word. After `por_ni` both words read 0xFFFF.
- R2: On the first clock after `rst_ni` releases, `lock_o` takes the value (stored security word == 0x0001). It then holds that value until the next reset, even if the stored word changes.
- R3: On the clock that samples the lock, `lock_o` is 1 and any request is refused: `port_en_o` is 0 and `access_denied_o` is 1 on the next cycle.
- R4: While locked, a request with `dbg_i`=1 is refused in every mode and for every kind: `port_en_o`=0, `access_denied_o`=1, `rd_data_o`=0xFFFF.
- R5: While locked in user mode (`mode_i`=00), non-debug requests of every kind are granted, and reads return valid array data.
- R6: While locked in any mode other than 00 (serial-writer mode is 01), a read is granted but returns 0xFFFF with `rd_valid_o`=0 and `access_denied_o`=1.
- R7: While locked in a mode other than 00, program (01) and sector erase (11) are refused and leave the stored words unchanged. Chip erase (10) is granted.
- R8: A granted chip erase, followed by `erase_done_i`, sets both stored words to 0xFFFF. `lock_o` stays 1 until the next reset and reads 0 after it.
- R9: A granted sector erase to either protected address, followed by `erase_done_i`, blanks both words. A sector erase to any other address leaves both words unchanged.
- R10: All outputs are registered and answer a request on the next cycle. When no request is present, `port_en_o`, `rd_valid_o` and `access_denied_o` are 0 and `rd_data_o` is 0xFFFF. Access kinds: 00 read, 01 program, 10 chip erase, 11 sector erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release samples the lock |
| por_ni | input | 1 | Active-low power-on reset of the stored words (blank part) |
| mode_i | input | 2 | Boot mode pins; 00 user, 01 serial writer |
| dbg_i | input | 1 | Request comes from the debug port |
| acc_valid_i | input | 1 | Request present this cycle |
| acc_kind_i | input | 2 | 00 read, 01 program, 10 chip erase, 11 sector erase |
| acc_addr_i | input | 32 | Byte address of the access |
| acc_wdata_i | input | 16 | Program data |
| array_rdata_i | input | 16 | Read data from the flash array at acc_addr_i |
| erase_done_i | input | 1 | Erase completion event from the array |
| port_en_o | output | 1 | Access granted to the flash |
| rd_valid_o | output | 1 | rd_data_o holds valid read data |
| rd_data_o | output | 16 | Read data, all ones when not valid |
| access_denied_o | output | 1 | One-cycle pulse on a refused or blanked access |
| lock_o | output | 1 | Sampled lock state |

## Verification
The bench writes the protection code and checks that `lock_o` does not move until a reset. A design that latched the lock at once would lock immediately. The bench also issues a request on the very clock that samples the lock, where a design that defaulted to unlocked would briefly grant access. In serial-writer mode it tries program and sector erase against the security word and then reads the word back in user mode, so a gate that refused only reads would be caught by the changed word. It also checks that one sector erase blanks the trim word along with the security word, that a sector erase elsewhere leaves both words intact, and that a chip erase releases the lock only after a reset.

// File: rtl/flock_pkg.sv
package flock_pkg;
  typedef enum logic [1:0] {
    K_READ = 2'b00,
    K_PROG = 2'b01,
    K_CHIP = 2'b10,
    K_SECT = 2'b11
  } acc_kind_e;

  localparam logic [1:0] MODE_USER = 2'b00;
endpackage

// File: rtl/flock_state.sv
module flock_state #(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] LOCK_CODE = 16'h0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sec_word_i,
  output logic          ready_o,
  output logic          lock_o
);
  logic ready_q, lock_q;

  // lock defaults to set until the stored word has been sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      lock_q  <= 1'b1;
    end else if (!ready_q) begin
      ready_q <= 1'b1;
      lock_q  <= (sec_word_i == LOCK_CODE);
    end
  end

  assign ready_o = ready_q;
  assign lock_o  = lock_q;

  a_r2_lock_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ready_q && $stable(lock_q));
endmodule

// File: rtl/flock_store.sv
module flock_store #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          wr_sec_i,
  input  logic          wr_trim_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          arm_erase_i,
  input  logic          erase_done_i,
  output logic [DW-1:0] sec_o,
  output logic [DW-1:0] trim_o
);
  logic [DW-1:0] sec_q, trim_q;
  logic          pend_q;
  logic          wipe;

  assign wipe = erase_done_i && pend_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      sec_q  <= '1;
      trim_q <= '1;
      pend_q <= 1'b0;
    end else if (wipe) begin
      sec_q  <= '1;
      trim_q <= '1;
      pend_q <= 1'b0;
    end else begin
      if (wr_sec_i)    sec_q  <= sec_q & wdata_i;
      if (wr_trim_i)   trim_q <= trim_q & wdata_i;
      if (arm_erase_i) pend_q <= 1'b1;
    end
  end

  assign sec_o  = sec_q;
  assign trim_o = trim_q;

  a_r1_sec_bits_clear_only: assert property (@(posedge clk_i) disable iff (!por_ni)
    !wipe |=> ((sec_q & ~$past(sec_q)) == '0));
  a_r1_trim_bits_clear_only: assert property (@(posedge clk_i) disable iff (!por_ni)
    !wipe |=> ((trim_q & ~$past(trim_q)) == '0));
  a_r8_erase_blanks_both: assert property (@(posedge clk_i) disable iff (!por_ni)
    wipe |=> (sec_q == '1) && (trim_q == '1));
endmodule

// File: rtl/flock_gate.sv
module flock_gate
  import flock_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic          lock_i,
  input  logic          acc_valid_i,
  input  logic          dbg_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    kind_i,
  input  logic [DW-1:0] rd_word_i,
  output logic          grant_o,
  output logic          port_en_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          denied_o
);
  logic deny_all, restricted, kind_ok, rd_ok, denied;
  logic pe_q, rv_q, dn_q;
  logic [DW-1:0] rd_q;

  always_comb begin
    deny_all   = !ready_i || (lock_i && dbg_i);
    restricted = lock_i && (mode_i != MODE_USER);
    kind_ok    = !restricted || (kind_i == K_READ) || (kind_i == K_CHIP);
    grant_o    = acc_valid_i && !deny_all && kind_ok;
    rd_ok      = grant_o && (kind_i == K_READ) && !restricted;
    denied     = acc_valid_i && (!grant_o || ((kind_i == K_READ) && !rd_ok));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_q <= 1'b0;
      rv_q <= 1'b0;
      dn_q <= 1'b0;
      rd_q <= '1;
    end else begin
      pe_q <= grant_o;
      rv_q <= rd_ok;
      dn_q <= denied;
      rd_q <= rd_ok ? rd_word_i : '1;
    end
  end

  assign port_en_o  = pe_q;
  assign rd_valid_o = rv_q;
  assign rd_data_o  = rd_q;
  assign denied_o   = dn_q;

  a_r3_no_grant_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !port_en_o);
  a_r4_dbg_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && dbg_i && lock_i |=> !port_en_o && denied_o && (rd_data_o == '1));
  a_r6_restricted_read_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && ready_i && !dbg_i && lock_i && (mode_i != MODE_USER) && (kind_i == K_READ)
    |=> port_en_o && !rd_valid_o && (rd_data_o == '1));
  a_r7_restricted_cmd_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && lock_i && (mode_i != MODE_USER) && ((kind_i == K_PROG) || (kind_i == K_SECT))
    |=> !port_en_o && denied_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !port_en_o && !denied_o && !rd_valid_o);
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flock_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] SEC_ADDR  = 32'h0010_0000,
  parameter logic [AW-1:0] TRIM_ADDR = 32'h0010_0004,
  parameter logic [DW-1:0] LOCK_CODE = 16'h0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic [1:0]    mode_i,
  input  logic          dbg_i,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_kind_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_wdata_i,
  input  logic [DW-1:0] array_rdata_i,
  input  logic          erase_done_i,
  output logic          port_en_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          access_denied_o,
  output logic          lock_o
);
  logic          hit_sec, hit_trim, grant, ready, lock;
  logic          wr_sec, wr_trim, arm_erase;
  logic [DW-1:0] sec_word, trim_word, rd_word;

  assign hit_sec  = (acc_addr_i == SEC_ADDR);
  assign hit_trim = (acc_addr_i == TRIM_ADDR);

  always_comb begin
    if (hit_sec)       rd_word = sec_word;
    else if (hit_trim) rd_word = trim_word;
    else               rd_word = array_rdata_i;
  end

  assign wr_sec    = grant && (acc_kind_i == K_PROG) && hit_sec;
  assign wr_trim   = grant && (acc_kind_i == K_PROG) && hit_trim;
  // both protected words share one erase unit
  assign arm_erase = grant && ((acc_kind_i == K_CHIP) ||
                               ((acc_kind_i == K_SECT) && (hit_sec || hit_trim)));

  flock_state #(.DW(DW), .LOCK_CODE(LOCK_CODE)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_word_i (sec_word),
    .ready_o    (ready),
    .lock_o     (lock)
  );

  flock_store #(.DW(DW)) u_store (
    .clk_i        (clk_i),
    .por_ni       (por_ni),
    .wr_sec_i     (wr_sec),
    .wr_trim_i    (wr_trim),
    .wdata_i      (acc_wdata_i),
    .arm_erase_i  (arm_erase),
    .erase_done_i (erase_done_i),
    .sec_o        (sec_word),
    .trim_o       (trim_word)
  );

  flock_gate #(.DW(DW)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ready),
    .lock_i      (lock),
    .acc_valid_i (acc_valid_i),
    .dbg_i       (dbg_i),
    .mode_i      (mode_i),
    .kind_i      (acc_kind_i),
    .rd_word_i   (rd_word),
    .grant_o     (grant),
    .port_en_o   (port_en_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .denied_o    (access_denied_o)
  );

  assign lock_o = lock;
endmodule

// File: tb/flash_lock_ctrl_tb.sv
module flash_lock_ctrl_tb;
  localparam logic [31:0] SEC  = 32'h0010_0000;
  localparam logic [31:0] TRIM = 32'h0010_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic [1:0]  mode = 2'b00, kind = 2'b00;
  logic        dbg = 1'b0, valid = 1'b0, edone = 1'b0;
  logic [31:0] addr = '0;
  logic [15:0] wdata = '0, arr;
  logic        pe, rv, dn, lk;
  logic [15:0] rd;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R10";

  // behavioural reference state
  logic [15:0] m_sec = 16'hFFFF, m_trim = 16'hFFFF;
  logic        m_pend = 1'b0, m_ready = 1'b0, m_lock = 1'b1;
  logic        e_pe = 1'b0, e_rv = 1'b0, e_dn = 1'b0;
  logic [15:0] e_rd = 16'hFFFF;

  assign arr = addr[15:0] ^ 16'hA55A;
  always #4 clk = ~clk;

  flash_lock_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .mode_i(mode), .dbg_i(dbg),
    .acc_valid_i(valid), .acc_kind_i(kind), .acc_addr_i(addr), .acc_wdata_i(wdata),
    .array_rdata_i(arr), .erase_done_i(edone), .port_en_o(pe), .rd_valid_o(rv),
    .rd_data_o(rd), .access_denied_o(dn), .lock_o(lk)
  );

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    logic blocked, limited, ok, rdok;
    logic [15:0] word, sec_old;
    if (!por_n) begin
      m_sec = 16'hFFFF; m_trim = 16'hFFFF; m_pend = 1'b0;
    end
    if (!rst_n) begin
      m_ready = 1'b0; m_lock = 1'b1;
      e_pe = 1'b0; e_rv = 1'b0; e_dn = 1'b0; e_rd = 16'hFFFF;
    end else if (por_n) begin
      sec_old = m_sec;
      blocked = !m_ready || (m_lock && dbg);
      limited = m_lock && (mode != 2'b00);
      ok   = valid && !blocked && (!limited || kind == 2'b00 || kind == 2'b10);
      rdok = ok && kind == 2'b00 && !limited;
      word = (addr == SEC) ? m_sec : (addr == TRIM) ? m_trim : arr;
      e_pe = ok;
      e_rv = rdok;
      e_rd = rdok ? word : 16'hFFFF;
      e_dn = valid && (!ok || (kind == 2'b00 && !rdok));
      if (edone && m_pend) begin
        m_sec = 16'hFFFF; m_trim = 16'hFFFF; m_pend = 1'b0;
      end else begin
        if (ok && kind == 2'b01 && addr == SEC)  m_sec  = m_sec & wdata;
        if (ok && kind == 2'b01 && addr == TRIM) m_trim = m_trim & wdata;
        if (ok && (kind == 2'b10 || (kind == 2'b11 && (addr == SEC || addr == TRIM))))
          m_pend = 1'b1;
      end
      if (!m_ready) begin
        m_ready = 1'b1;
        m_lock  = (sec_old == 16'h0001);
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && por_n) begin
      checks++;
      if ({pe, rv, dn, lk, rd} !== {e_pe, e_rv, e_dn, m_lock, e_rd}) begin
        errors++;
        $display("FAIL %s: pe/rv/dn/lock/rd actual %b%b%b%b %h expected %b%b%b%b %h",
                 tag, pe, rv, dn, lk, rd, e_pe, e_rv, e_dn, m_lock, e_rd);
      end
    end
  end

  task automatic req(input string t, input logic [1:0] k, input logic [31:0] a,
                     input logic [15:0] d, input logic dg);
    @(negedge clk);
    tag = t; kind = k; addr = a; wdata = d; dbg = dg; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; dbg = 1'b0;
  endtask

  task automatic erase_done(input string t);
    @(negedge clk);
    tag = t; edone = 1'b1;
    @(negedge clk);
    edone = 1'b0;
  endtask

  // reset; optionally a request on the sampling clock
  task automatic do_reset(input logic power, input logic probe);
    @(negedge clk);
    rst_n = 1'b0;
    if (power) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    if (probe) begin
      tag = "R3"; kind = 2'b00; addr = 32'h0000_0100; valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic chk_lock(input string t, input logic exp);
    checks++;
    if (lk !== exp) begin
      errors++;
      $display("FAIL %s: lock_o actual %b expected %b", t, lk, exp);
    end
  endtask

  initial begin
    do_reset(1'b1, 1'b0);
    chk_lock("R2", 1'b0);
    req("R5", 2'b00, 32'h0000_0200, 16'h0, 1'b0);
    req("R1", 2'b00, SEC, 16'h0, 1'b0);
    req("R1", 2'b01, TRIM, 16'h1234, 1'b0);
    req("R1", 2'b00, TRIM, 16'h0, 1'b0);
    req("R1", 2'b01, SEC, 16'h0001, 1'b0);
    req("R1", 2'b01, SEC, 16'hFFFF, 1'b0);
    req("R1", 2'b00, SEC, 16'h0, 1'b0);
    chk_lock("R2", 1'b0);
    req("R10", 2'b00, 32'h0000_0300, 16'h0, 1'b1);
    // lock takes effect on reset
    do_reset(1'b0, 1'b1);
    chk_lock("R2", 1'b1);
    req("R4", 2'b00, 32'h0000_0010, 16'h0, 1'b1);
    req("R4", 2'b01, SEC, 16'h0000, 1'b1);
    req("R4", 2'b10, 32'h0, 16'h0, 1'b1);
    req("R5", 2'b00, 32'h0000_0444, 16'h0, 1'b0);
    req("R5", 2'b11, 32'h0000_8000, 16'h0, 1'b0);
    erase_done("R9");
    req("R9", 2'b00, TRIM, 16'h0, 1'b0);
    mode = 2'b01;
    req("R6", 2'b00, 32'h0000_0444, 16'h0, 1'b0);
    req("R6", 2'b00, SEC, 16'h0, 1'b0);
    req("R7", 2'b01, SEC, 16'h0000, 1'b0);
    req("R7", 2'b11, SEC, 16'h0, 1'b0);
    erase_done("R7");
    mode = 2'b00;
    req("R7", 2'b00, SEC, 16'h0, 1'b0);
    req("R7", 2'b00, TRIM, 16'h0, 1'b0);
    mode = 2'b01;
    req("R7", 2'b10, 32'h0000_0000, 16'h0, 1'b0);
    erase_done("R8");
    req("R8", 2'b00, SEC, 16'h0, 1'b0);
    mode = 2'b00;
    req("R8", 2'b00, SEC, 16'h0, 1'b0);
    req("R8", 2'b00, TRIM, 16'h0, 1'b0);
    chk_lock("R8", 1'b1);
    do_reset(1'b0, 1'b0);
    chk_lock("R8", 1'b0);
    // sector erase through the trim word
    req("R9", 2'b01, SEC, 16'h0001, 1'b0);
    req("R9", 2'b01, TRIM, 16'h00F0, 1'b0);
    req("R9", 2'b11, TRIM, 16'h0, 1'b0);
    erase_done("R9");
    req("R9", 2'b00, SEC, 16'h0, 1'b0);
    req("R9", 2'b00, TRIM, 16'h0, 1'b0);
    do_reset(1'b0, 1'b0);
    chk_lock("R9", 1'b0);
    mode = 2'b10;
    req("R10", 2'b00, 32'h0000_0040, 16'h0, 1'b0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 5000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule